// File: doc/BRIEF.md
# Legacy Interrupt Collector for a PCIe Root Port

This block gathers legacy INTx assert and deassert events from the four interrupt lanes below a PCIe root port. Each event is stored in a small queue as a two-word entry. Software reads the oldest entry through two head-word registers and removes it by writing either of them. Around the queue sit four more registers. A decode register holds sticky write-1-to-clear cause bits for INTx and MSI. A mask register selects which causes drive the interrupt line. A PHY status register shows the link-up state. A port control/status register holds the bridge enable bit, shows whether the queue is non-empty, and carries a sticky overflow flag.

The interrupt output is a level. It is high whenever a decode bit and the matching mask bit are both set. While the queue holds anything, the INTx decode bit reads as set, so clearing it does not hide pending entries. The queue keeps one slot free to tell full from empty. An event that arrives when no slot is usable is lost, and the overflow flag records the loss.

Top module: `pcie_intx_collector`

## Requirements
- R1: A read strobe returns data on `reg_rdata` in the next cycle, with `reg_rdata_valid` high. Reads of any offset other than 0x138, 0x13C, 0x144, 0x148, 0x158 and 0x15C return zero. After reset the decode, mask, overflow, bridge-enable and queue state are all clear.
- R2: At offset 0x138, decode bit 16 is set by every queued INTx event and bit 17 by every `msi_hit` pulse. A write to 0x138 clears each decode bit whose write-data bit is 1. A set arriving in the same cycle as the clear wins.
- R3: While the queue is non-empty, decode bit 16 reads as 1. `irq_o` is high exactly when the read value of the decode register ANDed with the mask register is non-zero.
- R4: The mask register at 0x13C is a full 32-bit read/write register.
- R5: The head word 1 at 0x158 carries the lane in bits 28:27, the assert level in bit 29 and a valid flag (1) in bit 31. All its other bits are 0. Head word 2 at 0x15C always reads 0.
- R6: With depth D, the queue holds at most D-1 entries. An event that arrives while D-1 entries are held is dropped, and it sets the overflow flag, bit 19 of 0x148. Writing 1 to bit 19 of 0x148 clears the flag.
- R7: Reading 0x158 or 0x15C does not remove the head entry. When the queue is empty, 0x158 reads 0.
- R8: A write of any data to 0x158 or 0x15C removes the head entry. On an empty queue such a write has no effect.
- R9: Bit 0 of 0x148 is the bridge enable. It is read/write and drives `mem_win_en_o`. Bit 18 of 0x148 reads 1 when the queue is non-empty.
- R10: Bit 11 of the PHY status register at 0x144 reflects `link_up` at the time of the read. Every other bit of it reads 0.
- R11: Entries come out in the order their events arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One INTx event this cycle |
| evt_lane | input | 2 | Lane of the event (0..3) |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| msi_hit | input | 1 | One-cycle MSI receipt pulse |
| link_up | input | 1 | Link state shown in PHY status |
| reg_wr_valid | input | 1 | Register write strobe |
| reg_rd_valid | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rdata_valid | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt |
| mem_win_en_o | output | 1 | Memory window enable (bridge enable) |

## Verification
The bench builds the block with its default depth of 16, so 15 entries are usable. This depth is small enough that a directed burst of 20 events reaches the drop-and-flag path. The random phase then crosses the full boundary repeatedly while pops and reads are interleaved. It also exercises pops on an empty queue, the ordering of entries across pointer wrap-around, and the interplay between the forced INTx decode bit and write-1-to-clear.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_DECODE = 12'h138;
  localparam logic [REG_AW-1:0] OFS_MASK   = 12'h13C;
  localparam logic [REG_AW-1:0] OFS_PHY    = 12'h144;
  localparam logic [REG_AW-1:0] OFS_CTL    = 12'h148;
  localparam logic [REG_AW-1:0] OFS_HEAD1  = 12'h158;
  localparam logic [REG_AW-1:0] OFS_HEAD2  = 12'h15C;

  localparam int BIT_INTX     = 16;
  localparam int BIT_MSI      = 17;
  localparam int BIT_LINK     = 11;
  localparam int BIT_BRIDGE   = 0;
  localparam int BIT_NONEMPTY = 18;
  localparam int BIT_OVF      = 19;
  localparam int LANE_LSB     = 27;
  localparam int LEVEL_BIT    = 29;
  localparam int VALID_BIT    = 31;

  typedef struct packed {
    logic [1:0] lane;
    logic       level;
  } intx_evt_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DECODE, SEL_MASK, SEL_PHY, SEL_CTL, SEL_HEAD1, SEL_HEAD2
  } reg_sel_e;

  function automatic reg_sel_e addr_select(input logic [REG_AW-1:0] a);
    case (a)
      OFS_DECODE: return SEL_DECODE;
      OFS_MASK:   return SEL_MASK;
      OFS_PHY:    return SEL_PHY;
      OFS_CTL:    return SEL_CTL;
      OFS_HEAD1:  return SEL_HEAD1;
      OFS_HEAD2:  return SEL_HEAD2;
      default:    return SEL_NONE;
    endcase
  endfunction

  function automatic logic [REG_DW-1:0] pack_head_word1(input intx_evt_t e);
    logic [REG_DW-1:0] w;
    w = '0;
    w[LANE_LSB +: 2] = e.lane;
    w[LEVEL_BIT]     = e.level;
    w[VALID_BIT]     = 1'b1;
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] bit_at(input logic v, input int pos);
    logic [REG_DW-1:0] w;
    w = '0;
    w[pos] = v;
    return w;
  endfunction
endpackage

// File: rtl/intx_event_fifo.sv
module intx_event_fifo
  import intx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  intx_evt_t        push_evt,
  input  logic             pop_req,
  output logic             empty,
  output intx_evt_t        head_evt,
  output logic             push_ok,
  output logic             push_drop,
  output logic             pop_ok,
  output logic [CNT_W-1:0] fill
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] fill_of(input logic [PTR_W-1:0] w,
                                               input logic [PTR_W-1:0] r);
    if (w >= r) return CNT_W'(w) - CNT_W'(r);
    return CNT_W'(w) + CNT_W'(DEPTH) - CNT_W'(r);
  endfunction

  intx_evt_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full;

  assign empty     = (wr_ptr == rd_ptr);
  assign full      = (ptr_advance(wr_ptr) == rd_ptr);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop_req && !empty;
  assign head_evt  = slots[rd_ptr];
  assign fill      = fill_of(wr_ptr, rd_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_advance(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_advance(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= push_evt;
  end
endmodule

// File: rtl/intx_irq_status.sv
module intx_irq_status
  import intx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [REG_DW-1:0] wdata,
  input  logic              set_intx,
  input  logic              set_msi,
  input  logic              fifo_nonempty,
  output logic [REG_DW-1:0] decode_o,
  output logic [REG_DW-1:0] mask_o,
  output logic              irq_o
);
  logic [REG_DW-1:0] dec_q, mask_q, set_bits, clr_bits;

  assign set_bits = bit_at(set_intx, BIT_INTX) | bit_at(set_msi, BIT_MSI);
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '0;
      mask_q <= '0;
    end else begin
      dec_q <= (dec_q & ~clr_bits) | set_bits;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign decode_o = dec_q | bit_at(fifo_nonempty, BIT_INTX);
  assign mask_o   = mask_q;
  assign irq_o    = |(decode_o & mask_q);
endmodule

// File: rtl/intx_port_ctrl.sv
module intx_port_ctrl
  import intx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_DW-1:0] wdata,
  input  logic              drop,
  output logic              bridge_en_o,
  output logic              ovf_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bridge_en_o <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      if (ctl_we) bridge_en_o <= wdata[BIT_BRIDGE];
      if (drop)                         ovf_o <= 1'b1;
      else if (ctl_we && wdata[BIT_OVF]) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcie_intx_collector.sv
module pcie_intx_collector
  import intx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_valid,
  input  logic [1:0]  evt_lane,
  input  logic        evt_level,
  input  logic        msi_hit,
  input  logic        link_up,
  input  logic        reg_wr_valid,
  input  logic        reg_rd_valid,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rdata_valid,
  output logic        irq_o,
  output logic        mem_win_en_o
);
  reg_sel_e          sel;
  logic              wr_decode, wr_mask, wr_ctl, pop_req;
  logic              fifo_empty, push_ok, push_drop, pop_ok, ovf_flag;
  logic [CNT_W-1:0]  fill_count;
  intx_evt_t         in_evt, head_evt;
  logic [REG_DW-1:0] decode_val, mask_val, rd_mux, rdata_q;
  logic              rvalid_q;

  assign sel       = addr_select(reg_addr);
  assign wr_decode = reg_wr_valid && (sel == SEL_DECODE);
  assign wr_mask   = reg_wr_valid && (sel == SEL_MASK);
  assign wr_ctl    = reg_wr_valid && (sel == SEL_CTL);
  assign pop_req   = reg_wr_valid && ((sel == SEL_HEAD1) || (sel == SEL_HEAD2));
  assign in_evt    = '{lane: evt_lane, level: evt_level};

  intx_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (evt_valid),
    .push_evt  (in_evt),
    .pop_req   (pop_req),
    .empty     (fifo_empty),
    .head_evt  (head_evt),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .pop_ok    (pop_ok),
    .fill      (fill_count)
  );

  intx_irq_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_we        (wr_decode),
    .mask_we       (wr_mask),
    .wdata         (reg_wdata),
    .set_intx      (push_ok),
    .set_msi       (msi_hit),
    .fifo_nonempty (!fifo_empty),
    .decode_o      (decode_val),
    .mask_o        (mask_val),
    .irq_o         (irq_o)
  );

  intx_port_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (wr_ctl),
    .wdata       (reg_wdata),
    .drop        (push_drop),
    .bridge_en_o (mem_win_en_o),
    .ovf_o       (ovf_flag)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DECODE: rd_mux = decode_val;
      SEL_MASK:   rd_mux = mask_val;
      SEL_PHY:    rd_mux = bit_at(link_up, BIT_LINK);
      SEL_CTL:    rd_mux = bit_at(ovf_flag, BIT_OVF) | bit_at(!fifo_empty, BIT_NONEMPTY)
                         | bit_at(mem_win_en_o, BIT_BRIDGE);
      SEL_HEAD1:  rd_mux = fifo_empty ? '0 : pack_head_word1(head_evt);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= reg_rd_valid ? rd_mux : '0;
      rvalid_q <= reg_rd_valid;
    end
  end

  assign reg_rdata       = rdata_q;
  assign reg_rdata_valid = rvalid_q;
endmodule

// File: rtl/intx_collector_chk.sv
module intx_collector_chk
  import intx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_valid,
  input logic             reg_rd_valid,
  input logic [11:0]      reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             link_up,
  input logic             mem_win_en_o,
  input logic [31:0]      decode_val,
  input logic             fifo_empty,
  input logic             push_drop,
  input logic             pop_req,
  input logic             pop_ok,
  input logic [CNT_W-1:0] fill_count,
  input logic             ovf_flag
);
  p_intx_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |-> decode_val[BIT_INTX]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(FIFO_DEPTH - 1));

  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |-> (fill_count == CNT_W'(FIFO_DEPTH - 1)));

  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_flag);

  p_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fifo_empty) |-> !pop_ok);

  p_bridge_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && reg_addr == OFS_CTL) |=> (mem_win_en_o == $past(reg_wdata[BIT_BRIDGE])));

  p_link_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_valid && reg_addr == OFS_PHY) |=>
      (reg_rdata == ($past(link_up) ? 32'h0000_0800 : 32'h0)));

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_valid && addr_select(reg_addr) == SEL_NONE) |=> (reg_rdata == 32'h0));
endmodule

bind pcie_intx_collector intx_collector_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_valid (reg_wr_valid),
  .reg_rd_valid (reg_rd_valid),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .link_up      (link_up),
  .mem_win_en_o (mem_win_en_o),
  .decode_val   (decode_val),
  .fifo_empty   (fifo_empty),
  .push_drop    (push_drop),
  .pop_req      (pop_req),
  .pop_ok       (pop_ok),
  .fill_count   (fill_count),
  .ovf_flag     (ovf_flag)
);

// File: tb/tb_pcie_intx_collector.sv
module tb_pcie_intx_collector;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_level = 1'b0, msi_hit = 1'b0, link_up = 1'b0;
  logic [1:0]  evt_lane = '0;
  logic        reg_wr_valid = 1'b0, reg_rd_valid = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rdata_valid, irq_o, mem_win_en_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] q[$];
  logic [31:0] m_dec = '0, m_mask = '0;
  logic        m_ovf = 1'b0, m_bridge = 1'b0;

  always #4 clk = ~clk;

  pcie_intx_collector #(.FIFO_DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] exp_word1(input logic [1:0] lane, input logic level);
    return {1'b1, 1'b0, level, lane, 27'd0};
  endfunction
  function automatic logic [31:0] exp_decode();
    return m_dec | ((q.size() != 0) ? 32'h0001_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] exp_ctl();
    return {12'd0, m_ovf, q.size() != 0, 17'd0, m_bridge};
  endfunction
  function automatic logic [31:0] exp_head1();
    return (q.size() != 0) ? q[0] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_valid = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_valid = 1'b0;
    case (a)
      12'h138: m_dec = m_dec & ~d;
      12'h13C: m_mask = d;
      12'h148: begin m_bridge = d[0]; if (d[19]) m_ovf = 1'b0; end
      12'h158, 12'h15C: if (q.size() != 0) void'(q.pop_front());
      default: ;
    endcase
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_valid = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd_valid = 1'b0;
    d = reg_rdata;
    chk("R1", "read valid strobe", {31'd0, reg_rdata_valid}, 32'd1);
  endtask

  task automatic send_evt(input logic [1:0] lane, input logic level);
    @(negedge clk);
    evt_valid = 1'b1; evt_lane = lane; evt_level = level;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    if (q.size() < DEPTH - 1) begin
      q.push_back(exp_word1(lane, level));
      m_dec[16] = 1'b1;
    end else m_ovf = 1'b1;
  endtask

  task automatic pulse_msi();
    @(negedge clk);
    msi_hit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msi_hit = 1'b0;
    m_dec[17] = 1'b1;
  endtask

  task automatic check_irq(input string req);
    chk(req, "irq level", {31'd0, irq_o}, {31'd0, |(exp_decode() & m_mask)});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state and unmapped reads
    reg_rd(12'h138, d); chk("R1", "decode after reset", d, 32'h0);
    reg_rd(12'h13C, d); chk("R1", "mask after reset", d, 32'h0);
    reg_rd(12'h148, d); chk("R1", "ctl after reset", d, 32'h0);
    reg_rd(12'h158, d); chk("R7", "head1 empty", d, 32'h0);
    reg_rd(12'h140, d); chk("R1", "unmapped 0x140", d, 32'h0);
    reg_rd(12'h000, d); chk("R1", "unmapped 0x000", d, 32'h0);
    chk("R1", "irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R9", "window enable after reset", {31'd0, mem_win_en_o}, 32'd0);

    // R10 link status
    reg_rd(12'h144, d); chk("R10", "phy with link down", d, 32'h0);
    link_up = 1'b1;
    reg_rd(12'h144, d); chk("R10", "phy with link up", d, 32'h0000_0800);

    // R4 mask read/write
    reg_wr(12'h13C, 32'hA5C3_0F96);
    reg_rd(12'h13C, d); chk("R4", "mask readback", d, 32'hA5C3_0F96);
    reg_wr(12'h13C, 32'h0);

    // R5 R7 R11 entries, peeking without pop
    send_evt(2'd3, 1'b1);
    send_evt(2'd1, 1'b0);
    send_evt(2'd2, 1'b1);
    reg_rd(12'h158, d); chk("R5", "head word1 lane3 assert", d, 32'hB800_0000);
    reg_rd(12'h15C, d); chk("R5", "head word2 zero", d, 32'h0);
    reg_rd(12'h158, d); chk("R7", "read does not pop", d, 32'hB800_0000);
    reg_rd(12'h148, d); chk("R9", "nonempty bit", d, exp_ctl());
    reg_rd(12'h138, d); chk("R3", "intx forced", d, 32'h0001_0000);
    check_irq("R3");
    reg_wr(12'h13C, 32'h0001_0000);
    chk("R3", "irq with intx unmasked", {31'd0, irq_o}, 32'd1);
    reg_wr(12'h138, 32'hFFFF_FFFF);
    reg_rd(12'h138, d); chk("R2", "clear while nonempty keeps bit16", d, 32'h0001_0000);
    check_irq("R3");

    // R8 R11 pops through both words
    reg_wr(12'h15C, 32'h0);
    reg_rd(12'h158, d); chk("R11", "second entry", d, 32'h8800_0000);
    reg_wr(12'h158, 32'h1234_5678);
    reg_rd(12'h158, d); chk("R11", "third entry", d, exp_word1(2'd2, 1'b1));
    reg_wr(12'h158, 32'h0);
    reg_rd(12'h158, d); chk("R7", "empty after pops", d, 32'h0);
    reg_wr(12'h15C, 32'h0);
    send_evt(2'd0, 1'b1);
    reg_rd(12'h158, d); chk("R8", "empty pop ignored", d, 32'hA000_0000);
    reg_wr(12'h158, 32'h0);

    // R2 decode clear and MSI
    reg_rd(12'h138, d); chk("R2", "sticky intx after drain", d, 32'h0001_0000);
    reg_wr(12'h138, 32'h0001_0000);
    reg_rd(12'h138, d); chk("R2", "intx cleared", d, 32'h0);
    check_irq("R3");
    pulse_msi();
    reg_rd(12'h138, d); chk("R2", "msi sets bit17", d, 32'h0002_0000);
    chk("R3", "msi masked off", {31'd0, irq_o}, 32'd0);
    reg_wr(12'h13C, 32'h0002_0000);
    chk("R3", "msi unmasked", {31'd0, irq_o}, 32'd1);
    reg_wr(12'h138, 32'h0002_0000);
    reg_rd(12'h138, d); chk("R2", "msi cleared", d, 32'h0);
    check_irq("R3");

    // R9 bridge enable
    reg_wr(12'h148, 32'h1);
    chk("R9", "window enable set", {31'd0, mem_win_en_o}, 32'd1);
    reg_rd(12'h148, d); chk("R9", "bridge bit readback", d, exp_ctl());

    // R6 overflow
    for (int i = 0; i < 20; i++) send_evt(2'(i), 1'(i >> 2));
    reg_rd(12'h148, d); chk("R6", "overflow flag set", d, exp_ctl());
    chk("R6", "model holds D-1", 32'(q.size()), 32'(DEPTH - 1));
    reg_wr(12'h148, 32'h0008_0001);
    reg_rd(12'h148, d); chk("R6", "overflow cleared", d, exp_ctl());
    for (int i = 0; i < DEPTH - 1; i++) begin
      reg_rd(12'h158, d); chk("R11", "drain order", d, exp_head1());
      reg_wr(12'h15C, 32'h0);
    end
    reg_rd(12'h158, d); chk("R6", "nothing beyond D-1", d, 32'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      case (op)
        0, 1, 2: send_evt(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        3: reg_wr($urandom_range(0, 1) ? 12'h158 : 12'h15C, $urandom);
        4: begin reg_rd(12'h158, d); chk("R11", "random head", d, exp_head1()); end
        5: begin reg_rd(12'h148, d); chk("R6", "random ctl", d, exp_ctl()); end
        6: begin reg_rd(12'h138, d); chk("R2", "random decode", d, exp_decode()); check_irq("R3"); end
        default: begin
          if ($urandom_range(0, 1)) reg_wr(12'h138, $urandom);
          else reg_wr(12'h148, {12'd0, 1'($urandom_range(0, 1)), 18'd0, 1'($urandom_range(0, 1))});
          check_irq("R3");
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule